// File: doc/BRIEF.md
# SMBus Register Slave with Byte and Block Transfers

This block is a serial slave on a two-wire SMBus link. It gives a bus host read and write access to a bank of 8-bit control registers. The host first sends a command byte. Bit 7 of that byte picks the transfer style: 1 selects a single-byte transfer and 0 selects a block transfer. Bits [6:0] give the first register to access. A block transfer always carries a byte count ahead of its data bytes, and the register pointer steps by one after every data byte.

The block synchronises SCL and SDA into the system clock and finds START, repeated START and STOP conditions. It matches its 7-bit device address and pulls SDA low through an open-drain enable for acknowledges and for read data. The register bank sits outside the block. The block writes to it through a one-cycle strobe with address and data. It reads from it through a read address and a combinational data return.

The control state machine has nine states:
- S_IDLE: the bus is free.
- S_ADDR: the address byte is being shifted in.
- S_RX: a command, count or data byte is being shifted in.
- S_ACKW: waits for the SCL fall before the acknowledge bit.
- S_ACK: the slave drives or withholds its acknowledge.
- S_TX: a byte is being shifted out.
- S_TXACK: the master's acknowledge is sampled.
- S_TXLD: waits for the SCL fall before loading the next read byte.
- S_IGNORE: the bus is ignored.

START moves any state to S_ADDR. STOP moves any state to S_IDLE. The remaining transitions are:
- S_ADDR to S_ACKW after 8 bits when the address matches, and to S_IGNORE when it does not.
- S_RX to S_ACKW after 8 bits.
- S_ACKW to S_ACK on the SCL fall.
- S_ACK on the SCL fall: to S_TX for a read, to S_RX for a write, or to S_IGNORE after a withheld acknowledge.
- S_TX to S_TXACK after 8 bits.
- S_TXACK to S_TXLD when the master acknowledges, and to S_IGNORE when it does not.
- S_TXLD to S_TX on the SCL fall.

Top module: `smb_reg_slave`

## Requirements
- R1: After reset the block does not drive SDA (sda_oe = 0) and issues no register write strobe.
- R2: An address byte is 7 address bits, MSB first, then a direction bit (0 = write, 1 = read). The slave acknowledges when the 7 bits equal DEV_ADDR (default 7'h69). On any other address it gives no acknowledge and acknowledges nothing further until the next START. SDA is never driven while the block is idle.
- R3: Byte write uses START, address+write, a command byte with bit 7 = 1 and register number in bits [6:0], one data byte, then STOP. Every byte is acknowledged, and exactly one single-cycle write strobe carries that register and data.
- R4: Byte read uses address+write and a command byte with bit 7 = 1. A repeated START and address+read follow. The slave then returns the content of the named register, MSB first.
- R5: Block write uses a command byte with bit 7 = 0, then a count byte N, then data bytes. The data bytes go to consecutive registers starting at bits [6:0]. The first N data bytes are acknowledged and written. Any data byte beyond N receives no acknowledge and is not written.
- R6: Block read uses a command byte with bit 7 = 0, a repeated START and address+read. The slave returns a count byte equal to BLK_RD_LEN (default 8), then consecutive registers starting at bits [6:0], for as long as the master acknowledges.
- R7: When the master does not acknowledge a read byte, the slave releases SDA. It drives nothing on further clocks until STOP or START.
- R8: Registers at addresses RO_BASE (default 112 = 0x70) and above are read-only. Writes to them are acknowledged but produce no write strobe.
- R9: A START or STOP in the middle of a byte abandons the transfer in progress without writing. The next transfer then proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | REG_AW | Register written |
| reg_wr_data | output | 8 | Data written |
| reg_rd_addr | output | REG_AW | Register being read |
| reg_rd_data | input | 8 | Content of reg_rd_addr, same cycle |

## Verification
Pin edges reach the state machine through two synchroniser flops and one edge-detect flop. As a result, the register write strobe comes about four system clocks after the SCL rise of a data byte's eighth bit. SDA drive changes about four clocks after each SCL fall. The bench runs the bus with eight-clock quarter bits and samples SDA only in the middle of the SCL high phase, long after every drive change has settled. It compares register contents and the count of write strobes only after the STOP of each transfer.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_RX,
        S_ACKW,
        S_ACK,
        S_TX,
        S_TXACK,
        S_TXLD,
        S_IGNORE
    } smb_state_t;

    typedef enum logic [1:0] {
        P_CMD,
        P_CNT,
        P_DATA
    } smb_phase_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], d[i]};
        end
        assign q[i] = pipe[STAGES-1];
    end

endmodule

// File: rtl/smb_cond_det.sv
module smb_cond_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic evt_start,
    output logic evt_stop,
    output logic scl_rise,
    output logic scl_fall
);

    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign evt_start = scl_d & scl_s & sda_d & ~sda_s;
    assign evt_stop  = scl_d & scl_s & ~sda_d & sda_s;
    assign scl_rise  = ~scl_d & scl_s;
    assign scl_fall  = scl_d & ~scl_s;

endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
    import smb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         REG_AW      = 7,
    parameter int         RO_BASE     = 112,
    parameter int         BLK_RD_LEN  = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic              reg_wr_en,
    output logic [REG_AW-1:0] reg_wr_addr,
    output logic [7:0]        reg_wr_data,
    output logic [REG_AW-1:0] reg_rd_addr,
    input  logic [7:0]        reg_rd_data
);

    localparam logic [7:0]        CNT8    = 8'(BLK_RD_LEN);
    localparam logic [REG_AW-1:0] PTR_ONE = REG_AW'(1);

    logic scl_s, sda_s;
    logic evt_start, evt_stop, scl_rise, scl_fall;

    smb_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     ({scl_s, sda_s})
    );

    smb_cond_det u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .evt_start (evt_start),
        .evt_stop  (evt_stop),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    smb_state_t        state, nxt;
    smb_phase_t        phase;
    logic [2:0]        bitcnt;
    logic [7:0]        shreg;
    logic [7:0]        remain;
    logic [REG_AW-1:0] ptr;
    logic              blk, rd_dir, ack_q, cnt_pend;
    logic [7:0]        rx_byte, tx_byte;
    logic              byte_done, addr_hit, bus_idle;

    assign rx_byte     = {shreg[6:0], sda_s};
    assign byte_done   = scl_rise && (bitcnt == 3'd7);
    assign addr_hit    = (rx_byte[7:1] == DEV_ADDR);
    assign tx_byte     = cnt_pend ? CNT8 : reg_rd_data;
    assign reg_rd_addr = ptr;
    assign bus_idle    = (state == S_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (evt_start) begin
            nxt = S_ADDR;
        end else if (evt_stop) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE, S_IGNORE: nxt = state;
                S_ADDR:  if (byte_done) nxt = addr_hit ? S_ACKW : S_IGNORE;
                S_RX:    if (byte_done) nxt = S_ACKW;
                S_ACKW:  if (scl_fall) nxt = S_ACK;
                S_ACK:   if (scl_fall) nxt = !ack_q ? S_IGNORE : (rd_dir ? S_TX : S_RX);
                S_TX:    if (scl_fall && bitcnt == 3'd7) nxt = S_TXACK;
                S_TXACK: if (scl_rise) nxt = sda_s ? S_IGNORE : S_TXLD;
                S_TXLD:  if (scl_fall) nxt = S_TX;
                default: nxt = S_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe      <= 1'b0;
            reg_wr_en   <= 1'b0;
            reg_wr_addr <= '0;
            reg_wr_data <= '0;
            bitcnt      <= '0;
            shreg       <= '0;
            remain      <= '0;
            ptr         <= '0;
            phase       <= P_CMD;
            blk         <= 1'b0;
            rd_dir      <= 1'b0;
            ack_q       <= 1'b0;
            cnt_pend    <= 1'b0;
        end else begin
            reg_wr_en <= 1'b0;
            if (evt_start) begin
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (evt_stop) begin
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    S_ADDR: if (scl_rise) begin
                        shreg  <= rx_byte;
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7 && addr_hit) begin
                            ack_q    <= 1'b1;
                            rd_dir   <= rx_byte[0];
                            cnt_pend <= blk;
                            if (!rx_byte[0]) phase <= P_CMD;
                        end
                    end
                    S_RX: if (scl_rise) begin
                        shreg  <= rx_byte;
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) begin
                            ack_q <= 1'b1;
                            unique case (phase)
                                P_CMD: begin
                                    ptr   <= rx_byte[REG_AW-1:0];
                                    blk   <= ~rx_byte[7];
                                    phase <= rx_byte[7] ? P_DATA : P_CNT;
                                end
                                P_CNT: begin
                                    remain <= rx_byte;
                                    phase  <= P_DATA;
                                end
                                P_DATA: begin
                                    if (blk && remain == 8'd0) begin
                                        ack_q <= 1'b0;
                                    end else begin
                                        if (32'(ptr) < RO_BASE) begin
                                            reg_wr_en   <= 1'b1;
                                            reg_wr_addr <= ptr;
                                            reg_wr_data <= rx_byte;
                                        end
                                        ptr <= ptr + PTR_ONE;
                                        if (blk) remain <= remain - 8'd1;
                                    end
                                end
                                default: phase <= P_CMD;
                            endcase
                        end
                    end
                    S_ACKW: if (scl_fall) sda_oe <= ack_q;
                    S_ACK: if (scl_fall) begin
                        bitcnt <= '0;
                        if (ack_q && rd_dir) begin
                            shreg  <= tx_byte;
                            sda_oe <= ~tx_byte[7];
                            if (cnt_pend) cnt_pend <= 1'b0;
                            else          ptr <= ptr + PTR_ONE;
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                    S_TX: if (scl_fall) begin
                        if (bitcnt == 3'd7) begin
                            sda_oe <= 1'b0;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= ~shreg[6];
                            bitcnt <= bitcnt + 3'd1;
                        end
                    end
                    S_TXLD: if (scl_fall) begin
                        bitcnt <= '0;
                        shreg  <= tx_byte;
                        sda_oe <= ~tx_byte[7];
                        if (cnt_pend) cnt_pend <= 1'b0;
                        else          ptr <= ptr + PTR_ONE;
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk #(
    parameter int REG_AW  = 7,
    parameter int RO_BASE = 112
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              sda_oe,
    input logic              reg_wr_en,
    input logic [REG_AW-1:0] reg_wr_addr,
    input logic              bus_idle
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!sda_oe && !reg_wr_en));

    // R2
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle |-> !sda_oe);

    // R2
    drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R3
    strobe_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> scl_s);

    // R8
    strobe_rw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (32'(reg_wr_addr) < RO_BASE));

endmodule

bind smb_reg_slave smb_reg_slave_chk #(.REG_AW(REG_AW), .RO_BASE(RO_BASE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (scl_s),
    .sda_oe      (sda_oe),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .bus_idle    (bus_idle)
);

// File: tb/smb_reg_slave_bench.sv
module smb_reg_slave_bench;

    localparam logic [6:0] DEV  = 7'h69;
    localparam int         RO   = 112;
    localparam int         BLEN = 8;
    localparam int         QTR  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe, reg_wr_en;
    logic [6:0] reg_wr_addr, reg_rd_addr;
    logic [7:0] reg_wr_data, reg_rd_data;

    logic [7:0] mem [128];
    logic [7:0] expv [128];
    int wr_cnt = 0;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    assign sda_line    = sda_m & ~sda_oe;
    assign reg_rd_data = mem[reg_rd_addr];

    smb_reg_slave u_smb_reg_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (scl_m),
        .sda_in      (sda_line),
        .sda_oe      (sda_oe),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data),
        .reg_rd_addr (reg_rd_addr),
        .reg_rd_data (reg_rd_data)
    );

    always @(posedge clk) begin
        if (reg_wr_en) begin
            mem[reg_wr_addr] <= reg_wr_data;
            wr_cnt <= wr_cnt + 1;
        end
    end

    function automatic logic [7:0] init_val(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    function automatic bit writable(input int a);
        return (a & 127) < RO;
    endfunction

    task automatic check(input string req, input int act, input int exp_v);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic qd();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; qd(); scl_m = 1'b1; qd(); sda_m = 1'b0; qd(); scl_m = 1'b0; qd();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; qd(); scl_m = 1'b1; qd(); sda_m = 1'b1; qd(); qd();
    endtask

    task automatic m_bit(input logic b, output logic s);
        sda_m = b; qd(); scl_m = 1'b1; qd(); s = sda_line; qd(); scl_m = 1'b0; qd();
    endtask

    task automatic m_send(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) m_bit(b[i], s);
        m_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic m_recv(input logic ack_m, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, s);
            d[i] = s;
        end
        m_bit(~ack_m, s);
    endtask

    task automatic wr_byte(input logic [6:0] ra, input logic [7:0] dat, input string req);
        logic a0, a1, a2;
        m_start();
        m_send({DEV, 1'b0}, a0);
        m_send({1'b1, ra}, a1);
        m_send(dat, a2);
        m_stop();
        check({req, " byte write acks"}, {29'd0, a0, a1, a2}, 7);
        if (writable(int'(ra))) expv[ra] = dat;
    endtask

    task automatic rd_byte(input logic [6:0] ra, output logic [7:0] d, output logic [2:0] acks);
        logic a0, a1, a2;
        m_start();
        m_send({DEV, 1'b0}, a0);
        m_send({1'b1, ra}, a1);
        m_start();
        m_send({DEV, 1'b1}, a2);
        m_recv(1'b0, d);
        m_stop();
        acks = {a0, a1, a2};
    endtask

    logic [7:0] bdat [8];
    logic [7:0] rdat [8];

    task automatic wr_block(input logic [6:0] base, input int cnt, input int n, input string req);
        logic a;
        m_start();
        m_send({DEV, 1'b0}, a);
        check({req, " addr ack"}, int'(a), 1);
        m_send({1'b0, base}, a);
        m_send(8'(cnt), a);
        check({req, " count ack"}, int'(a), 1);
        for (int i = 0; i < n; i++) begin
            m_send(bdat[i], a);
            check({req, " data ack"}, int'(a), (i < cnt) ? 1 : 0);
            if (i < cnt && writable(int'(base) + i)) expv[(int'(base) + i) & 127] = bdat[i];
        end
        m_stop();
    endtask

    task automatic rd_block(input logic [6:0] base, output logic [7:0] cnt);
        logic a;
        m_start();
        m_send({DEV, 1'b0}, a);
        m_send({1'b0, base}, a);
        m_start();
        m_send({DEV, 1'b1}, a);
        m_recv(1'b1, cnt);
        for (int i = 0; i < BLEN; i++) m_recv(i < BLEN - 1, rdat[i]);
    endtask

    task automatic cmp_regs(input string req);
        int diffs = 0;
        for (int i = 0; i < 128; i++) if (mem[i] !== expv[i]) diffs++;
        check({req, " register file mismatches"}, diffs, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d, c;
        logic [2:0] acks;
        logic a, s;
        int w0;
        for (int i = 0; i < 128; i++) begin
            mem[i]  = init_val(i);
            expv[i] = init_val(i);
        end
        void'($urandom(32'd20240));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        check("R1 sda_oe", int'(sda_oe), 0);
        check("R1 reg_wr_en", int'(reg_wr_en), 0);

        // R3 byte write
        w0 = wr_cnt;
        wr_byte(7'h05, 8'hA5, "R3");
        check("R3 strobe count", wr_cnt - w0, 1);
        check("R3 reg 05", int'(mem[5]), 8'hA5);

        // R4 byte read
        rd_byte(7'h05, d, acks);
        check("R4 acks", int'(acks), 7);
        check("R4 read 05", int'(d), 8'hA5);
        rd_byte(7'h20, d, acks);
        check("R4 read 20", int'(d), int'(init_val(32)));

        // R2 address mismatch ignored until next START
        w0 = wr_cnt;
        m_start();
        m_send({7'h12, 1'b0}, a);
        check("R2 wrong address nack", int'(a), 0);
        m_send({DEV, 1'b0}, a);
        check("R2 ignored after mismatch", int'(a), 0);
        m_send(8'h85, a);
        m_send(8'h3C, a);
        check("R2 ignored data", int'(a), 0);
        m_stop();
        check("R2 no strobe", wr_cnt - w0, 0);

        // R5 block write with overflow byte
        bdat[0] = 8'h11; bdat[1] = 8'h22; bdat[2] = 8'h33; bdat[3] = 8'h44;
        w0 = wr_cnt;
        wr_block(7'h10, 3, 4, "R5");
        check("R5 strobes", wr_cnt - w0, 3);
        cmp_regs("R5");

        // R6 block read
        rd_block(7'h10, c);
        check("R6 count byte", int'(c), BLEN);
        for (int i = 0; i < BLEN; i++) check("R6 block data", int'(rdat[i]), int'(expv[16 + i]));
        // R7 released after master NACK
        d = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, s);
            d[i] = s;
        end
        check("R7 line released", int'(d), 8'hFF);
        m_stop();

        // R8 read-only registers
        w0 = wr_cnt;
        wr_byte(7'h72, 8'h5A, "R8");
        check("R8 no strobe", wr_cnt - w0, 0);
        rd_byte(7'h72, d, acks);
        check("R8 read-only kept", int'(d), int'(init_val(114)));
        bdat[0] = 8'hE1; bdat[1] = 8'hE2;
        w0 = wr_cnt;
        wr_block(7'h6F, 2, 2, "R8 block");
        check("R8 block strobes", wr_cnt - w0, 1);
        cmp_regs("R8");

        // R9 START in mid byte, then STOP in mid byte
        m_start();
        m_send({DEV, 1'b0}, a);
        for (int i = 0; i < 4; i++) m_bit(1'b1, s);
        wr_byte(7'h07, 8'h77, "R9");
        check("R9 reg 07", int'(mem[7]), 8'h77);
        w0 = wr_cnt;
        m_start();
        m_send({DEV, 1'b0}, a);
        m_send({1'b1, 7'h09}, a);
        for (int i = 0; i < 3; i++) m_bit(1'b0, s);
        m_stop();
        check("R9 no strobe on abort", wr_cnt - w0, 0);
        rd_byte(7'h09, d, acks);
        check("R9 read after abort", int'(d), int'(expv[9]));

        // random byte traffic, R3 and R4
        for (int k = 0; k < 12; k++) begin
            logic [6:0] ra;
            logic [7:0] rv;
            ra = 7'($urandom_range(RO - 1, 0));
            rv = 8'($urandom_range(255, 0));
            wr_byte(ra, rv, "R3 random");
            rd_byte(ra, d, acks);
            check("R4 random read", int'(d), int'(rv));
        end

        // random block traffic, R5 and R6
        for (int k = 0; k < 4; k++) begin
            logic [6:0] base;
            int n;
            base = 7'($urandom_range(90, 0));
            n = $urandom_range(4, 1);
            for (int i = 0; i < 8; i++) bdat[i] = 8'($urandom_range(255, 0));
            wr_block(base, n, n, "R5 random");
            rd_block(base, c);
            m_stop();
            check("R6 random count", int'(c), BLEN);
            for (int i = 0; i < BLEN; i++)
                check("R6 random data", int'(rdat[i]), int'(expv[(int'(base) + i) & 127]));
        end
        cmp_regs("R5 final");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule